// File: doc/BRIEF.md
# Store Set Memory Dependence Predictor

This block predicts which earlier store a load or store should wait for in an out-of-order core. It keeps two tables. The set table is indexed by instruction address and gives each trained memory instruction a set number. The last-store table is indexed by set number and holds the sequence number of the youngest dispatched store of that set. When the core finds a load that ran ahead of a store it depended on, it trains the predictor with both addresses, and the two instructions join one set. Later dispatches of that set's stores are recorded. A lookup of any member then returns the sequence number it must wait for, or zero for "no dependence".

Each command port is a single-beat valid channel that is always accepted. There is no ready and no back-pressure: every beat with its valid high is consumed on the rising clock edge where it is seen. The lookup is a combinational read of the registered state, so it reflects every update made at or before the last edge. To keep sets from filling up, the predictor counts dispatched loads and stores and forgets all it has learned once the count passes a programmable period.

Top module: `memdep_pred`

## Requirements
- R1: After a synchronous reset, every lookup returns zero and the operation count is zero.
- R2: The set table index is address bits [2 +: log2(ID_N)]. The two lowest address bits are ignored, and addresses that agree in the index bits share one entry.
- R3: Training where neither the load's nor the store's set entry is valid creates set number load_pc[2 +: log2(LS_N)] and writes it, marked valid, into both entries.
- R4: Training where exactly one of the two entries is valid copies that entry's set number into the other entry and marks it valid.
- R5: Training where both entries are valid overwrites the entry that holds the larger set number with the smaller one. The other entry keeps its value.
- R6: A dispatched store (disp_is_store=1) whose set entry is valid writes its sequence number into that set's last-store entry and marks it valid. A store with an invalid set entry, and any load (disp_is_store=0), leave the last-store table unchanged.
- R7: look_seq is zero when the set entry of look_pc is invalid, or when that set's last-store entry is invalid. Otherwise it is the recorded sequence number. A lookup sees updates from the following cycle on.
- R8: An issued store (iss_is_store=1) with a valid set entry invalidates that set's last-store entry if the entry holds exactly iss_seq. A mismatched sequence number, or an issued load, changes nothing.
- R9: A squash invalidates, in one cycle, every valid last-store entry whose sequence number is greater than squash_seq. Entries equal to or less than squash_seq stay.
- R10: Each dispatch (load or store) adds one to the operation count. The dispatch that would make the count exceed clear_period instead sets the count to zero and clears every valid bit in both tables, and all other updates in that cycle are discarded.
- R11: When training and a dispatch occur in the same cycle, the dispatch uses the set table as already updated by the training.
- R12: When a dispatch writes a last-store entry in the same cycle that an issue or squash would invalidate it, the dispatch write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| clear_period | input | CNT_W | Dispatches allowed before a full wipe |
| train_valid | input | 1 | Violation training beat |
| train_store_pc | input | PC_W | Address of the store that was violated |
| train_load_pc | input | PC_W | Address of the load that ran ahead |
| disp_valid | input | 1 | Memory instruction dispatch beat |
| disp_is_store | input | 1 | 1 = store, 0 = load |
| disp_pc | input | PC_W | Dispatched instruction address |
| disp_seq | input | SEQ_W | Dispatched sequence number (non-zero) |
| iss_valid | input | 1 | Memory instruction issue beat |
| iss_is_store | input | 1 | 1 = store, 0 = load |
| iss_pc | input | PC_W | Issued instruction address |
| iss_seq | input | SEQ_W | Issued sequence number |
| squash_valid | input | 1 | Squash beat |
| squash_seq | input | SEQ_W | Oldest surviving sequence number |
| look_pc | input | PC_W | Lookup address |
| look_seq | output | SEQ_W | Predicted store to wait for, zero if none |

## Verification
On every cycle the assertions check several things. The lookup is zero right after reset and right after a wipe. The operation count returns to zero on the dispatch that passes the period. A recorded store is visible at its own address in the next cycle. After a squash that has no dispatch beside it, no lookup returns anything younger than the squash point. After an issued store, its own sequence number is gone from its address. How sets form and merge on training, including which set number survives, can only be shown by the bench. Its scenarios walk each training case and sweep every set table index against an arithmetic model. The same holds for the aliasing of address bits and for the same-cycle ordering of training, dispatch, issue and squash.

// File: rtl/memdep_pkg.sv
package memdep_pkg;
  // instruction addresses are word aligned: low bits carry no index information
  localparam int unsigned PC_OFS = 2;
endpackage

// File: rtl/ssp_op_counter.sv
module ssp_op_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic [CNT_W-1:0] period,
  output logic             wipe,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W:0] cnt_plus;

  assign cnt_plus = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
  assign wipe     = inc && (cnt_plus > {1'b0, period});

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (wipe) cnt <= '0;
    else if (inc)  cnt <= cnt_plus[CNT_W-1:0];
  end
endmodule

// File: rtl/ssp_id_table.sv
module ssp_id_table
  import memdep_pkg::*;
#(
  parameter int PC_W = 16,
  parameter int ID_N = 16,
  parameter int LS_N = 8,
  localparam int IW  = $clog2(ID_N),
  localparam int SW  = $clog2(LS_N)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wipe,
  input  logic            trn_v,
  input  logic [PC_W-1:0] trn_st_pc,
  input  logic [PC_W-1:0] trn_ld_pc,
  // port a reads the table as updated by this cycle's training
  input  logic [PC_W-1:0] a_pc,
  output logic            a_hit,
  output logic [SW-1:0]   a_id,
  // ports b and c read the registered table
  input  logic [PC_W-1:0] b_pc,
  output logic            b_hit,
  output logic [SW-1:0]   b_id,
  input  logic [PC_W-1:0] c_pc,
  output logic            c_hit,
  output logic [SW-1:0]   c_id
);
  logic [SW-1:0]   id_q [ID_N];
  logic [SW-1:0]   id_n [ID_N];
  logic [ID_N-1:0] v_q, v_n;
  logic [IW-1:0]   ld_i, st_i, a_i, b_i, c_i;
  logic            ld_v, st_v;
  logic [SW-1:0]   fresh;

  assign ld_i  = trn_ld_pc[PC_OFS +: IW];
  assign st_i  = trn_st_pc[PC_OFS +: IW];
  assign ld_v  = v_q[ld_i];
  assign st_v  = v_q[st_i];
  assign fresh = trn_ld_pc[PC_OFS +: SW];

  always_comb begin
    id_n = id_q;
    v_n  = v_q;
    if (trn_v) begin
      if (!ld_v && !st_v) begin
        id_n[ld_i] = fresh;
        id_n[st_i] = fresh;
        v_n[ld_i]  = 1'b1;
        v_n[st_i]  = 1'b1;
      end else if (ld_v && !st_v) begin
        id_n[st_i] = id_q[ld_i];
        v_n[st_i]  = 1'b1;
      end else if (!ld_v && st_v) begin
        id_n[ld_i] = id_q[st_i];
        v_n[ld_i]  = 1'b1;
      end else if (id_q[st_i] > id_q[ld_i]) begin
        id_n[st_i] = id_q[ld_i];
      end else begin
        id_n[ld_i] = id_q[st_i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q <= '0;
    end else begin
      v_q  <= wipe ? '0 : v_n;
      id_q <= id_n;
    end
  end

  assign a_i   = a_pc[PC_OFS +: IW];
  assign b_i   = b_pc[PC_OFS +: IW];
  assign c_i   = c_pc[PC_OFS +: IW];
  assign a_hit = v_n[a_i];
  assign a_id  = id_n[a_i];
  assign b_hit = v_q[b_i];
  assign b_id  = id_q[b_i];
  assign c_hit = v_q[c_i];
  assign c_id  = id_q[c_i];
endmodule

// File: rtl/ssp_last_store.sv
module ssp_last_store #(
  parameter int LS_N  = 8,
  parameter int SEQ_W = 16,
  localparam int SW   = $clog2(LS_N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wipe,
  input  logic             wr_v,
  input  logic [SW-1:0]    wr_id,
  input  logic [SEQ_W-1:0] wr_seq,
  input  logic             iss_v,
  input  logic [SW-1:0]    iss_id,
  input  logic [SEQ_W-1:0] iss_seq,
  input  logic             sq_v,
  input  logic [SEQ_W-1:0] sq_seq,
  input  logic             rd_hit,
  input  logic [SW-1:0]    rd_id,
  output logic [SEQ_W-1:0] rd_seq
);
  logic [LS_N-1:0]  vld;
  logic [SEQ_W-1:0] seqs [LS_N];

  for (genvar g = 0; g < LS_N; g++) begin : g_ent
    logic             e_v;
    logic [SEQ_W-1:0] e_seq;
    logic             set_e, kill_e;

    assign set_e  = wr_v && (wr_id == SW'(g));
    assign kill_e = e_v && ((iss_v && (iss_id == SW'(g)) && (e_seq == iss_seq)) ||
                            (sq_v && (e_seq > sq_seq)));

    always_ff @(posedge clk) begin
      if (rst || wipe) begin
        e_v <= 1'b0;
      end else if (set_e) begin
        e_v   <= 1'b1;
        e_seq <= wr_seq;
      end else if (kill_e) begin
        e_v <= 1'b0;
      end
    end

    assign vld[g]  = e_v;
    assign seqs[g] = e_seq;
  end

  assign rd_seq = (rd_hit && vld[rd_id]) ? seqs[rd_id] : '0;
endmodule

// File: rtl/memdep_pred.sv
module memdep_pred #(
  parameter int PC_W  = 16,
  parameter int SEQ_W = 16,
  parameter int ID_N  = 16,
  parameter int LS_N  = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] clear_period,
  input  logic             train_valid,
  input  logic [PC_W-1:0]  train_store_pc,
  input  logic [PC_W-1:0]  train_load_pc,
  input  logic             disp_valid,
  input  logic             disp_is_store,
  input  logic [PC_W-1:0]  disp_pc,
  input  logic [SEQ_W-1:0] disp_seq,
  input  logic             iss_valid,
  input  logic             iss_is_store,
  input  logic [PC_W-1:0]  iss_pc,
  input  logic [SEQ_W-1:0] iss_seq,
  input  logic             squash_valid,
  input  logic [SEQ_W-1:0] squash_seq,
  input  logic [PC_W-1:0]  look_pc,
  output logic [SEQ_W-1:0] look_seq
);
  localparam int SW = $clog2(LS_N);

  logic             wipe;
  logic [CNT_W-1:0] op_cnt;
  logic             a_hit, b_hit, c_hit;
  logic [SW-1:0]    a_id, b_id, c_id;
  logic             disp_we, iss_we;

  ssp_op_counter #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst(rst), .inc(disp_valid), .period(clear_period),
    .wipe(wipe), .cnt(op_cnt)
  );

  ssp_id_table #(.PC_W(PC_W), .ID_N(ID_N), .LS_N(LS_N)) u_ids (
    .clk(clk), .rst(rst), .wipe(wipe),
    .trn_v(train_valid), .trn_st_pc(train_store_pc), .trn_ld_pc(train_load_pc),
    .a_pc(disp_pc), .a_hit(a_hit), .a_id(a_id),
    .b_pc(look_pc), .b_hit(b_hit), .b_id(b_id),
    .c_pc(iss_pc),  .c_hit(c_hit), .c_id(c_id)
  );

  assign disp_we = disp_valid && disp_is_store && a_hit;
  assign iss_we  = iss_valid && iss_is_store && c_hit;

  ssp_last_store #(.LS_N(LS_N), .SEQ_W(SEQ_W)) u_last (
    .clk(clk), .rst(rst), .wipe(wipe),
    .wr_v(disp_we), .wr_id(a_id), .wr_seq(disp_seq),
    .iss_v(iss_we), .iss_id(c_id), .iss_seq(iss_seq),
    .sq_v(squash_valid), .sq_seq(squash_seq),
    .rd_hit(b_hit), .rd_id(b_id), .rd_seq(look_seq)
  );
endmodule

// File: rtl/memdep_pred_chk.sv
module memdep_pred_chk #(
  parameter int PC_W  = 16,
  parameter int SEQ_W = 16,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] clear_period,
  input logic             train_valid,
  input logic             disp_valid,
  input logic [PC_W-1:0]  disp_pc,
  input logic [SEQ_W-1:0] disp_seq,
  input logic             iss_valid,
  input logic             iss_is_store,
  input logic [PC_W-1:0]  iss_pc,
  input logic [SEQ_W-1:0] iss_seq,
  input logic             squash_valid,
  input logic [SEQ_W-1:0] squash_seq,
  input logic [PC_W-1:0]  look_pc,
  input logic [SEQ_W-1:0] look_seq,
  input logic             wipe,
  input logic [CNT_W-1:0] op_cnt,
  input logic             disp_we
);
  // R1: nothing is predicted right after reset
  p_empty_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> look_seq == '0);

  // R10: the dispatch that passes the period returns the count to zero
  p_count_rollover_r10: assert property (@(posedge clk) disable iff (rst)
    (disp_valid && op_cnt >= clear_period) |=> op_cnt == '0);

  // R10: a wipe leaves no prediction anywhere
  p_wipe_empties_r10: assert property (@(posedge clk) disable iff (rst)
    wipe |=> look_seq == '0);

  // R6: a recorded store is predicted at its own address next cycle
  p_store_recorded_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(disp_we && !wipe && !rst) && look_pc == $past(disp_pc))
      |-> look_seq == $past(disp_seq));

  // R9: nothing younger than the squash point survives a squash
  p_squash_bound_r9: assert property (@(posedge clk) disable iff (rst)
    $past(squash_valid && !disp_valid && !rst)
      |-> (look_seq == '0 || look_seq <= $past(squash_seq)));

  // R8: an issued store no longer predicts itself
  p_issue_clears_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(iss_valid && iss_is_store && !disp_valid && !train_valid &&
           iss_seq != '0 && !rst) && look_pc == $past(iss_pc))
      |-> look_seq != $past(iss_seq));
endmodule

bind memdep_pred memdep_pred_chk #(.PC_W(PC_W), .SEQ_W(SEQ_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_memdep_pred.sv
`timescale 1ns/1ps
module sim_memdep_pred;
  localparam int PC_W = 16, SEQ_W = 16, ID_N = 16, LS_N = 8, CNT_W = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic [CNT_W-1:0] clear_period = 16'd1000;
  logic train_valid = 0, disp_valid = 0, disp_is_store = 0;
  logic iss_valid = 0, iss_is_store = 0, squash_valid = 0;
  logic [PC_W-1:0] train_store_pc = 0, train_load_pc = 0, disp_pc = 0, iss_pc = 0, look_pc = 0;
  logic [SEQ_W-1:0] disp_seq = 0, iss_seq = 0, squash_seq = 0, look_seq;

  always #4 clk = ~clk;  // 125 MHz

  memdep_pred #(.PC_W(PC_W), .SEQ_W(SEQ_W), .ID_N(ID_N), .LS_N(LS_N), .CNT_W(CNT_W)) u0 (.*);

  int n_chk = 0, n_fail = 0;

  // reference tables, updated from the requirements
  int unsigned m_id [ID_N];
  bit          m_iv [ID_N];
  int unsigned m_seq[LS_N];
  bit          m_lv [LS_N];
  int unsigned m_cnt = 0;

  function automatic int unsigned ix(int unsigned pc);  return (pc >> 2) % ID_N; endfunction
  function automatic int unsigned sx(int unsigned pc);  return (pc >> 2) % LS_N; endfunction

  function automatic int unsigned m_look(int unsigned pc);
    if (!m_iv[ix(pc)]) return 0;
    if (!m_lv[m_id[ix(pc)]]) return 0;
    return m_seq[m_id[ix(pc)]];
  endfunction

  task automatic m_wipe_all();
    for (int i = 0; i < ID_N; i++) m_iv[i] = 0;
    for (int i = 0; i < LS_N; i++) m_lv[i] = 0;
  endtask

  task automatic m_step();
    int unsigned li, si, kill_s;
    bit kill_v;
    if (disp_valid && (m_cnt + 1 > clear_period)) begin
      m_wipe_all();
      m_cnt = 0;
      return;
    end
    if (disp_valid) m_cnt++;
    kill_v = 0; kill_s = 0;
    if (iss_valid && iss_is_store && m_iv[ix(iss_pc)]) begin
      kill_s = m_id[ix(iss_pc)];
      kill_v = m_lv[kill_s] && (m_seq[kill_s] == iss_seq);
    end
    if (train_valid) begin
      li = ix(train_load_pc); si = ix(train_store_pc);
      if (!m_iv[li] && !m_iv[si]) begin
        m_id[li] = sx(train_load_pc); m_id[si] = sx(train_load_pc);
        m_iv[li] = 1; m_iv[si] = 1;
      end else if (m_iv[li] && !m_iv[si]) begin
        m_id[si] = m_id[li]; m_iv[si] = 1;
      end else if (!m_iv[li] && m_iv[si]) begin
        m_id[li] = m_id[si]; m_iv[li] = 1;
      end else if (m_id[si] > m_id[li]) m_id[si] = m_id[li];
      else m_id[li] = m_id[si];
    end
    if (kill_v) m_lv[kill_s] = 0;
    if (squash_valid)
      for (int s = 0; s < LS_N; s++) if (m_lv[s] && m_seq[s] > squash_seq) m_lv[s] = 0;
    if (disp_valid && disp_is_store && m_iv[ix(disp_pc)]) begin
      m_seq[m_id[ix(disp_pc)]] = disp_seq;
      m_lv[m_id[ix(disp_pc)]]  = 1;
    end
  endtask

  task automatic tick();
    @(posedge clk);
    m_step();
    #1;
    train_valid = 0; disp_valid = 0; iss_valid = 0; squash_valid = 0;
    disp_is_store = 0; iss_is_store = 0;
  endtask

  task automatic train(input int unsigned st, input int unsigned ld);
    train_valid = 1; train_store_pc = PC_W'(st); train_load_pc = PC_W'(ld); tick();
  endtask
  task automatic dstore(input int unsigned pc, input int unsigned sq);
    disp_valid = 1; disp_is_store = 1; disp_pc = PC_W'(pc); disp_seq = SEQ_W'(sq); tick();
  endtask
  task automatic dload(input int unsigned pc, input int unsigned sq);
    disp_valid = 1; disp_is_store = 0; disp_pc = PC_W'(pc); disp_seq = SEQ_W'(sq); tick();
  endtask
  task automatic issue(input bit st, input int unsigned pc, input int unsigned sq);
    iss_valid = 1; iss_is_store = st; iss_pc = PC_W'(pc); iss_seq = SEQ_W'(sq); tick();
  endtask
  task automatic squash(input int unsigned sq);
    squash_valid = 1; squash_seq = SEQ_W'(sq); tick();
  endtask

  task automatic chk(input int unsigned pc, input int unsigned exp, input string req);
    look_pc = PC_W'(pc);
    #1;
    n_chk++;
    if (look_seq !== SEQ_W'(exp)) begin
      n_fail++;
      $display("FAIL %s pc=%h look_seq=%0d expected=%0d", req, pc, look_seq, exp);
    end
  endtask

  // compare every set table index (with a random-looking low offset) to the model
  task automatic sweep(input string req);
    for (int i = 0; i < ID_N; i++) chk((i << 2) | (i % 4), m_look(i << 2), req);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    m_wipe_all();
    repeat (3) @(posedge clk);
    #1 rst = 0;
    sweep("R1");

    // R3: fresh set from load 0x2C -> set 3, store 0x10 -> index 4
    train(32'h10, 32'h2C);
    dstore(32'h10, 100);
    chk(32'h2C, 100, "R3");
    chk(32'h2C, 100, "R7");
    chk(32'h12, 100, "R2");   // low bits ignored
    chk(32'h50, 100, "R2");   // index 4 alias
    chk(32'h14, 0,   "R2");   // neighbouring index untouched
    dstore(32'h40, 101);      // invalid set entry
    chk(32'h40, 0, "R6");
    dload(32'h2C, 102);       // loads never record
    chk(32'h2C, 100, "R6");
    sweep("R3");

    // R4: store side joins the load's set, then load side joins the store's set
    train(32'h44, 32'h2C);
    dstore(32'h44, 110);
    chk(32'h2C, 110, "R4");
    train(32'h10, 32'h08);
    chk(32'h08, 110, "R4");
    sweep("R4");

    // R5: set 7 vs set 3, smaller number wins on either side
    train(32'h60, 32'h1C);
    dstore(32'h60, 120);
    chk(32'h1C, 120, "R5");
    train(32'h60, 32'h2C);
    chk(32'h60, 110, "R5");
    chk(32'h1C, 120, "R5");
    train(32'h10, 32'h1C);
    chk(32'h1C, 110, "R5");
    sweep("R5");

    // R8: mismatched store issue and load issue do nothing, matching store clears
    issue(1, 32'h60, 999);
    chk(32'h2C, 110, "R8");
    issue(0, 32'h44, 110);
    chk(32'h2C, 110, "R8");
    issue(1, 32'h44, 110);
    chk(32'h2C, 0, "R8");
    sweep("R8");

    // R9: set 5 holds 200, set 3 holds 210
    train(32'h80, 32'h34);
    dstore(32'h80, 200);
    dstore(32'h10, 210);
    squash(205);
    chk(32'h34, 200, "R9");
    chk(32'h2C, 0,   "R9");
    squash(200);
    chk(32'h34, 200, "R9");
    sweep("R9");

    // R11: training and dispatch in one cycle (set 6)
    train_valid = 1; train_store_pc = 16'h24; train_load_pc = 16'h38;
    disp_valid = 1; disp_is_store = 1; disp_pc = 16'h24; disp_seq = 300;
    tick();
    chk(32'h38, 300, "R11");

    // R12: dispatch beats a same-cycle issue of the old store and a squash
    disp_valid = 1; disp_is_store = 1; disp_pc = 16'h24; disp_seq = 310;
    iss_valid = 1; iss_is_store = 1; iss_pc = 16'h24; iss_seq = 300;
    squash_valid = 1; squash_seq = 305;
    tick();
    chk(32'h38, 310, "R12");
    sweep("R12");

    // R10: small period; count is already past it, so the next dispatch wipes
    clear_period = 3;
    dload(32'h00, 1);
    sweep("R10");
    train(32'h24, 32'h38);
    dstore(32'h24, 400);
    dload(32'h00, 401);
    dload(32'h00, 402);
    chk(32'h38, 400, "R10");
    dstore(32'h24, 410);      // fourth dispatch: wipe, store discarded
    chk(32'h38, 0, "R10");
    dstore(32'h24, 420);      // set entry gone, nothing recorded
    chk(32'h38, 0, "R10");
    sweep("R10");

    // R1: reset again after activity
    train(32'h24, 32'h38);
    dstore(32'h24, 500);
    rst = 1; @(posedge clk); m_wipe_all(); m_cnt = 0; #1 rst = 0;
    sweep("R1");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule